// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a simple synchronous host bus to a 256K x 16 asynchronous DRAM whose address pins are shared between row and column. The host raises a request with an 18-bit word address, a read/write flag, two byte enables and write data. The controller splits the address into a 9-bit row (upper bits) and a 9-bit column (lower bits), sequences the row strobe, the two byte-lane column strobes, the write strobe and the output enable, and answers with a one-cycle acknowledge that also qualifies read data.

A row stays open after an access. Later requests to the same row become short column-only cycles. A request to a different row closes the page, waits out precharge and opens the new row. A free-running timer requests a CAS-before-RAS refresh every 15.6 µs, which keeps all 512 rows inside their 8.2 ms retention budget. A due refresh wins over host traffic and closes any open page first. Every pulse width, precharge and access delay is derived in clock cycles from nanosecond parameters, rounded up, so other clock rates and speed grades need only new parameter values.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row (address bits 17..9) is on the DRAM address pins and stable on the clock edge where the row strobe falls. The column (bits 8..0) is there and stable on the edge where a column strobe falls.
- R2: Byte enable bit 0 drives the lower column strobe (data bits 7..0) and bit 1 drives the upper one (bits 15..8). A write changes only the enabled lanes. On a read, the disabled lanes of the returned data read as zero.
- R3: A request to the row that is already open is served with the row strobe held low, without a new row activation.
- R4: The row strobe stays high for at least the precharge time (2 cycles at 20 ns for 40 ns) before each falling edge, including on a row change.
- R5: A write drives the write strobe low and puts data on the bus at least one cycle before any column strobe falls. The output enable stays high for as long as the write strobe is low.
- R6: Each request gets exactly one acknowledge pulse one cycle wide. For a read, the data is valid in that same cycle.
- R7: A refresh pulls both column strobes low at least one cycle before the row strobe falls, with the write strobe and output enable high. Refreshes recur every 780 cycles (15.6 µs at 20 ns) and are never more than 800 cycles (16 µs) apart.
- R8: When a refresh falls due in the same cycle that a host request is seen, the refresh goes first. An open page is closed and precharged before the refresh, and the request then opens its row again.
- R9: During reset all DRAM strobes are high, the data bus is not driven and the acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request, held until acknowledged |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address, row in the upper 9 bits |
| be_i | input | 2 | Byte enables, bit 0 lower lane |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | One-cycle acknowledge, qualifies rdata_o |
| rdata_o | output | 16 | Read data, disabled lanes zero |
| dram_addr_o | output | 9 | Multiplexed DRAM address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_casl_n_o | output | 1 | Lower-lane column strobe, active low |
| dram_casu_n_o | output | 1 | Upper-lane column strobe, active low |
| dram_we_n_o | output | 1 | Write strobe, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Data driven to the DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 16 | Data returned by the DRAM |

## Verification
Two things can land in the same cycle: the refresh timer expiring and a host request to the row that is still open. The bench counts clock edges from reset release. It raises a same-row request exactly on the edge where the refresh becomes pending, while a page is open. The DRAM model timestamps every row activation and every refresh. The outcome passes only if one refresh happens, then exactly one new activation, and only then the acknowledge. A controller that served the page hit first would show no activation at all.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_RADR,
        SQ_ROW,
        SQ_CADR,
        SQ_COL,
        SQ_CPRE,
        SQ_OPEN,
        SQ_RPRE,
        SQ_RCAS,
        SQ_RRAS
    } seq_state_e;

    // ceiling division, never below one cycle
    function automatic int cdiv(input int num, input int den);
        int r;
        r = (num + den - 1) / den;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split #(
    parameter int ROW_W = 9,
    parameter int COL_W = 9
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col
);
    // row in the upper bits so that linear addresses stay inside one page
    assign row = addr[ROW_W+COL_W-1:COL_W];
    assign col = addr[COL_W-1:0];
endmodule

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
    parameter int REF_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic pend
);
    localparam int W = $clog2(REF_CYC);
    localparam logic [W-1:0] LAST = W'(REF_CYC - 1);

    logic [W-1:0] cnt_q, cnt_d;
    logic         pend_q, pend_d;

    always_comb begin
        cnt_d  = cnt_q + 1'b1;
        pend_d = pend_q;
        if (take) pend_d = 1'b0;
        if (cnt_q == LAST) begin
            cnt_d  = '0;
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/fpm_wait_cnt.sv
module fpm_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (ld)               cnt_d = ld_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_dram_pkg::*;
#(
    parameter int ROW_W     = 9,
    parameter int BYTE_W    = 8,
    parameter int CLK_NS    = 20,
    parameter int T_RAC_NS  = 60,
    parameter int T_CAC_NS  = 15,
    parameter int T_OEA_NS  = 15,
    parameter int T_RC_NS   = 110,
    parameter int T_RAS_NS  = 60,
    parameter int T_RP_NS   = 40,
    parameter int T_CP_NS   = 10,
    parameter int T_CSR_NS  = 10,
    parameter int REF_NS    = 15600
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic                     wr_i,
    input  logic [2*ROW_W-1:0]       addr_i,
    input  logic [1:0]               be_i,
    input  logic [2*BYTE_W-1:0]      wdata_i,
    output logic                     ack_o,
    output logic [2*BYTE_W-1:0]      rdata_o,
    output logic [ROW_W-1:0]         dram_addr_o,
    output logic                     dram_ras_n_o,
    output logic                     dram_casl_n_o,
    output logic                     dram_casu_n_o,
    output logic                     dram_we_n_o,
    output logic                     dram_oe_n_o,
    output logic [2*BYTE_W-1:0]      dram_dq_o,
    output logic                     dram_dq_oe_o,
    input  logic [2*BYTE_W-1:0]      dram_dq_i
);
    localparam int COL_W   = ROW_W;
    localparam int DATA_W  = 2 * BYTE_W;
    localparam int LANES   = 2;
    localparam int RCD_CYC = cdiv(T_RAC_NS - T_CAC_NS, CLK_NS);
    localparam int CAS_CYC = cdiv(imax(T_CAC_NS, T_OEA_NS), CLK_NS);
    localparam int CP_CYC  = cdiv(T_CP_NS, CLK_NS);
    localparam int CSR_CYC = cdiv(T_CSR_NS, CLK_NS);
    localparam int RAS_CYC = cdiv(T_RAS_NS, CLK_NS);
    localparam int RP_CYC  = imax(cdiv(T_RP_NS, CLK_NS), cdiv(T_RC_NS, CLK_NS) - RAS_CYC);
    localparam int REF_CYC = REF_NS / CLK_NS;
    localparam int MAX_CYC = imax(imax(RCD_CYC, CAS_CYC), imax(imax(CP_CYC, CSR_CYC), imax(RAS_CYC, RP_CYC)));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e          st;
        logic                ras_n;
        logic                casl_n;
        logic                casu_n;
        logic                we_n;
        logic                oe_n;
        logic [ROW_W-1:0]    addr;
        logic [DATA_W-1:0]   dq;
        logic                dq_oe;
        logic                ack;
        logic [DATA_W-1:0]   rdata;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic                wr;
        logic [LANES-1:0]    be;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: SQ_IDLE, ras_n: 1'b1, casl_n: 1'b1, casu_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
        addr: '0, dq: '0, dq_oe: 1'b0, ack: 1'b0, rdata: '0, row: '0, col: '0,
        wr: 1'b0, be: '0
    };

    ctl_t q, d;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             ref_pend, ref_take;
    logic             wt_ld, wt_zero;
    logic [CNT_W-1:0] wt_val;
    logic [DATA_W-1:0] lane_mask;

    fpm_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr(addr_i), .row(req_row), .col(req_col)
    );

    fpm_refresh_timer #(.REF_CYC(REF_CYC)) u_ref (
        .clk(clk), .rst_n(rst_n), .take(ref_take), .pend(ref_pend)
    );

    fpm_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .ld(wt_ld), .ld_val(wt_val), .zero(wt_zero)
    );

    // per-lane mask for returned read data
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*BYTE_W +: BYTE_W] = {BYTE_W{q.be[g]}};
    end

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        wt_ld    = 1'b0;
        wt_val   = '0;
        ref_take = 1'b0;

        unique case (q.st)
            SQ_IDLE: begin
                if (ref_pend) begin
                    // refresh first: column strobes lead the row strobe
                    ref_take = 1'b1;
                    d.casl_n = 1'b0;
                    d.casu_n = 1'b0;
                    d.st     = SQ_RCAS;
                    wt_ld    = 1'b1;
                    wt_val   = CNT_W'(CSR_CYC - 1);
                end else if (req_i) begin
                    d.row  = req_row;
                    d.col  = req_col;
                    d.wr   = wr_i;
                    d.be   = be_i;
                    d.dq   = wdata_i;
                    d.addr = req_row;
                    d.st   = SQ_RADR;
                end
            end
            SQ_RADR: begin
                d.ras_n = 1'b0;
                d.st    = SQ_ROW;
                wt_ld   = 1'b1;
                wt_val  = CNT_W'(RCD_CYC - 1);
            end
            SQ_ROW: begin
                if (wt_zero) begin
                    d.addr  = q.col;
                    d.we_n  = ~q.wr;
                    d.dq_oe = q.wr;
                    d.st    = SQ_CADR;
                end
            end
            SQ_CADR: begin
                d.casl_n = ~q.be[0];
                d.casu_n = ~q.be[1];
                d.oe_n   = q.wr;
                d.st     = SQ_COL;
                wt_ld    = 1'b1;
                wt_val   = CNT_W'(CAS_CYC - 1);
            end
            SQ_COL: begin
                if (wt_zero) begin
                    d.ack    = 1'b1;
                    d.rdata  = q.wr ? '0 : (dram_dq_i & lane_mask);
                    d.casl_n = 1'b1;
                    d.casu_n = 1'b1;
                    d.oe_n   = 1'b1;
                    d.we_n   = 1'b1;
                    d.dq_oe  = 1'b0;
                    d.st     = SQ_CPRE;
                    wt_ld    = 1'b1;
                    wt_val   = CNT_W'(CP_CYC - 1);
                end
            end
            SQ_CPRE: begin
                if (wt_zero) d.st = SQ_OPEN;
            end
            SQ_OPEN: begin
                if (ref_pend || (req_i && req_row != q.row)) begin
                    // close the page; IDLE then serves refresh or the new row
                    d.ras_n = 1'b1;
                    d.st    = SQ_RPRE;
                    wt_ld   = 1'b1;
                    wt_val  = CNT_W'(RP_CYC - 1);
                end else if (req_i) begin
                    d.col   = req_col;
                    d.wr    = wr_i;
                    d.be    = be_i;
                    d.dq    = wdata_i;
                    d.addr  = req_col;
                    d.we_n  = ~wr_i;
                    d.dq_oe = wr_i;
                    d.st    = SQ_CADR;
                end
            end
            SQ_RPRE: begin
                if (wt_zero) d.st = SQ_IDLE;
            end
            SQ_RCAS: begin
                if (wt_zero) begin
                    d.ras_n = 1'b0;
                    d.st    = SQ_RRAS;
                    wt_ld   = 1'b1;
                    wt_val  = CNT_W'(RAS_CYC - 1);
                end
            end
            SQ_RRAS: begin
                if (wt_zero) begin
                    d.ras_n  = 1'b1;
                    d.casl_n = 1'b1;
                    d.casu_n = 1'b1;
                    d.st     = SQ_RPRE;
                    wt_ld    = 1'b1;
                    wt_val   = CNT_W'(RP_CYC - 1);
                end
            end
            default: d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign ack_o         = q.ack;
    assign rdata_o       = q.rdata;
    assign dram_addr_o   = q.addr;
    assign dram_ras_n_o  = q.ras_n;
    assign dram_casl_n_o = q.casl_n;
    assign dram_casu_n_o = q.casu_n;
    assign dram_we_n_o   = q.we_n;
    assign dram_oe_n_o   = q.oe_n;
    assign dram_dq_o     = q.dq;
    assign dram_dq_oe_o  = q.dq_oe;

endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
    parameter int ROW_W  = 9,
    parameter int RP_CYC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             casl_n,
    input logic             casu_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [ROW_W-1:0] dram_addr,
    input logic             dq_oe,
    input logic             ack
);
    localparam logic [7:0] RP_L = 8'(RP_CYC);

    // cycles the row strobe has been sampled high, saturating
    logic [7:0] hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hi_q <= 8'hFF;
        else if (!ras_n)       hi_q <= '0;
        else if (hi_q != 8'hFF) hi_q <= hi_q + 8'd1;
    end

    a_r1_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && casl_n && casu_n) |-> $stable(dram_addr));

    a_r1_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(casl_n) || $fell(casu_n)) && !ras_n) |-> $stable(dram_addr));

    a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_q >= RP_L));

    a_r5_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(casl_n) || $fell(casu_n)) && !we_n) |-> ($past(!we_n) && $past(dq_oe) && dq_oe));

    a_r5_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r7_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && (!casl_n || !casu_n)) |->
            (!casl_n && !casu_n && we_n && oe_n && $past(!casl_n) && $past(!casu_n)));

endmodule

bind fpm_dram_ctrl fpm_dram_chk #(.ROW_W(ROW_W), .RP_CYC(RP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n_o), .casl_n(dram_casl_n_o),
    .casu_n(dram_casu_n_o), .we_n(dram_we_n_o), .oe_n(dram_oe_n_o),
    .dram_addr(dram_addr_o), .dq_oe(dram_dq_oe_o), .ack(ack_o)
);

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
    localparam int REF_EXP = 15600 / 20;   // R7 interval in cycles
    localparam int REF_MAX = 800;          // 16 us
    localparam int RP_MIN  = 2;            // 40 ns at 20 ns

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0, h_wr = 1'b0;
    logic [17:0] h_addr = '0;
    logic [1:0]  h_be = '0;
    logic [15:0] h_wdata = '0;
    logic        h_ack;
    logic [15:0] h_rdata;
    logic [8:0]  d_addr;
    logic        d_ras_n, d_casl_n, d_casu_n, d_we_n, d_oe_n, d_dq_oe;
    logic [15:0] d_dq_o, d_dq_i;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fpm_dram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(h_req), .wr_i(h_wr), .addr_i(h_addr),
        .be_i(h_be), .wdata_i(h_wdata), .ack_o(h_ack), .rdata_o(h_rdata),
        .dram_addr_o(d_addr), .dram_ras_n_o(d_ras_n), .dram_casl_n_o(d_casl_n),
        .dram_casu_n_o(d_casu_n), .dram_we_n_o(d_we_n), .dram_oe_n_o(d_oe_n),
        .dram_dq_o(d_dq_o), .dram_dq_oe_o(d_dq_oe), .dram_dq_i(d_dq_i)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural DRAM model ----------------
    logic [15:0] mdl_mem [int unsigned];
    logic [15:0] ref_mem [int unsigned];
    logic [8:0]  m_row = '0, m_col = '0;
    logic [15:0] m_rd = '0;
    int   m_act = 0, m_ref = 0, m_hi_cyc = 0, m_last_ref_cyc = 0;
    time  t_we = 0, t_cas = 0, t_last_ref = 0, t_last_act = 0;

    function automatic logic [15:0] mrd(input int unsigned k);
        return mdl_mem.exists(k) ? mdl_mem[k] : 16'h0;
    endfunction
    function automatic logic [15:0] rrd(input int unsigned k);
        return ref_mem.exists(k) ? ref_mem[k] : 16'h0;
    endfunction

    assign d_dq_i[7:0]  = (!d_ras_n && !d_casl_n && !d_oe_n && d_we_n) ? m_rd[7:0]  : 8'hA5;
    assign d_dq_i[15:8] = (!d_ras_n && !d_casu_n && !d_oe_n && d_we_n) ? m_rd[15:8] : 8'hA5;

    always @(negedge d_we_n) t_we = $time;
    always @(posedge d_ras_n) m_hi_cyc = cyc;

    always @(negedge d_ras_n) begin
        chk(cyc - m_hi_cyc >= RP_MIN, "R4 row precharge cycles", cyc - m_hi_cyc, RP_MIN);
        if (!d_casl_n || !d_casu_n) begin
            chk(!d_casl_n && !d_casu_n, "R7 both column strobes in refresh", {d_casu_n, d_casl_n}, 0);
            chk(d_we_n && d_oe_n, "R7 W and OE high in refresh", {d_we_n, d_oe_n}, 3);
            chk(t_cas < $time, "R7 column strobe before row strobe", t_cas, $time);
            chk(cyc - m_last_ref_cyc <= REF_MAX, "R7 refresh spacing max", cyc - m_last_ref_cyc, REF_MAX);
            if (m_ref > 0)
                chk(cyc - m_last_ref_cyc >= REF_EXP - 20, "R7 refresh spacing min", cyc - m_last_ref_cyc, REF_EXP);
            m_last_ref_cyc = cyc;
            t_last_ref = $time;
            m_ref++;
        end else begin
            m_row = d_addr;
            t_last_act = $time;
            m_act++;
        end
    end

    always @(negedge d_casl_n or negedge d_casu_n) begin
        t_cas = $time;
        if (!d_ras_n) begin
            logic [15:0] w;
            m_col = d_addr;
            if (!d_we_n) begin
                chk(d_dq_oe === 1'b1, "R5 data driven at column strobe", d_dq_oe, 1);
                chk(d_oe_n === 1'b1, "R5 OE high during write", d_oe_n, 1);
                chk(t_we < $time, "R5 W falls before column strobe", t_we, $time);
                w = mrd({m_row, m_col});
                if (!d_casl_n) w[7:0]  = d_dq_o[7:0];
                if (!d_casu_n) w[15:8] = d_dq_o[15:8];
                mdl_mem[{m_row, m_col}] = w;
            end else begin
                m_rd = mrd({m_row, m_col});
            end
        end
    end

    // ---------------- host side ----------------
    task automatic host_access(input logic w, input logic [17:0] a, input logic [1:0] b,
                               input logic [15:0] wd, output logic [15:0] rd);
        int n = 0;
        logic [15:0] v;
        h_req = 1'b1; h_wr = w; h_addr = a; h_be = b; h_wdata = wd;
        do begin @(negedge clk); n++; end while (!h_ack && n < 200);
        rd = h_rdata;
        h_req = 1'b0;
        chk(h_ack === 1'b1, "R6 acknowledge seen", h_ack, 1);
        if (b != 2'b00) begin
            chk(m_row == a[17:9], "R1 row on address pins", m_row, a[17:9]);
            chk(m_col == a[8:0], "R1 column on address pins", m_col, a[8:0]);
        end
        if (w) begin
            v = rrd(a);
            if (b[0]) v[7:0]  = wd[7:0];
            if (b[1]) v[15:8] = wd[15:8];
            ref_mem[a] = v;
        end
        @(negedge clk);
        chk(h_ack === 1'b0, "R6 acknowledge one cycle", h_ack, 0);
    endtask

    task automatic do_write(input logic [17:0] a, input logic [1:0] b, input logic [15:0] wd);
        logic [15:0] rd;
        host_access(1'b1, a, b, wd, rd);
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] b, input string tag);
        logic [15:0] rd, e;
        host_access(1'b0, a, b, 16'h0, rd);
        e = rrd(a) & {{8{b[1]}}, {8{b[0]}}};
        chk(rd === e, tag, rd, e);
    endtask

    task automatic wait_refresh();
        int r0 = m_ref;
        while (m_ref == r0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({d_ras_n, d_casl_n, d_casu_n, d_we_n, d_oe_n} === 5'h1F, "R9 strobes high in reset",
            {d_ras_n, d_casl_n, d_casu_n, d_we_n, d_oe_n}, 5'h1F);
        chk(h_ack === 1'b0 && d_dq_oe === 1'b0, "R9 ack and bus idle in reset", {h_ack, d_dq_oe}, 0);
    endtask

    task automatic t_words();
        do_write(18'h00000, 2'b11, 16'h1357);
        do_write(18'h3FFFF, 2'b11, 16'hBEEF);
        do_write(18'h2AA55, 2'b11, 16'h5AA5);
        do_write(18'h001FF, 2'b11, 16'hC001);
        do_read(18'h00000, 2'b11, "R6 read data word 0");
        do_read(18'h3FFFF, 2'b11, "R6 read data top word");
        do_read(18'h2AA55, 2'b11, "R1 read data mixed row/col");
        do_read(18'h001FF, 2'b11, "R1 read data last column");
    endtask

    task automatic t_lanes();
        do_write(18'h12345, 2'b11, 16'h1234);
        do_write(18'h12345, 2'b10, 16'hCDEF);
        do_read(18'h12345, 2'b11, "R2 upper lane merged");
        do_write(18'h12345, 2'b01, 16'h0099);
        do_read(18'h12345, 2'b01, "R2 lower lane only, upper zero");
        do_read(18'h12345, 2'b10, "R2 upper lane only, lower zero");
        do_read(18'h12345, 2'b11, "R2 word after lane writes");
    endtask

    task automatic t_page();
        int a0;
        wait_refresh();
        a0 = m_act;
        do_write(18'h0A801, 2'b11, 16'h1111);
        do_write(18'h0A802, 2'b11, 16'h2222);
        do_read(18'h0A801, 2'b11, "R3 page read 1");
        do_read(18'h0A802, 2'b11, "R3 page read 2");
        chk(m_act - a0 == 1, "R3 one activation for same row", m_act - a0, 1);
        do_read(18'h14801, 2'b11, "R4 read after row change");
        chk(m_act - a0 == 2, "R4 row change reopens", m_act - a0, 2);
    endtask

    task automatic t_collide();
        int a0, r0, target;
        logic [15:0] rd;
        wait_refresh();
        do_write(18'h1F0F0, 2'b11, 16'h7E57);
        target = (cyc / REF_EXP + 1) * REF_EXP;
        while (cyc != target) @(negedge clk);
        a0 = m_act; r0 = m_ref;
        // same-row request on the cycle the refresh falls due
        host_access(1'b0, 18'h1F0F1, 2'b11, 16'h0, rd);
        chk(m_ref - r0 == 1, "R8 refresh served", m_ref - r0, 1);
        chk(m_act - a0 == 1, "R8 page reopened after refresh", m_act - a0, 1);
        chk(t_last_ref < t_last_act, "R8 refresh before activation", t_last_ref, t_last_act);
        do_read(18'h1F0F0, 2'b11, "R8 data intact after refresh");
    endtask

    initial begin
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_words();
        t_lanes();
        t_page();
        t_collide();
        wait_refresh();
        chk(m_ref >= 3, "R7 refreshes keep occurring", m_ref, 3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule